// File: doc/BRIEF.md
# Cache Victim-Way Selector

This block picks which way of an E-way set-associative cache should be evicted when a line must be filled. The cache controller presents the set it is about to fill on `repl_set` and sees the chosen way on `victim_way` in the same cycle. When the controller commits a replacement it raises `repl_req`. Separately, every hit or fill is reported with `access_vld`, `access_set` and `access_way`, so that policies based on usage can track it. Tags, data arrays and the miss sequence are left to the surrounding cache. This block only holds and updates the replacement state.

A build-time parameter chooses one of three policies. First-in first-out keeps a wrapping pointer per set. Random keeps one wrapping counter shared by every set, and a second parameter decides what advances it. True LRU keeps a per-set list of way numbers ordered from oldest to newest. All pins are plain control strobes with no handshake. A strobe is taken on the rising clock edge where it is high. The victim is a combinational function of the stored state and `repl_set`, so the new choice appears in the cycle after the edge that applies a strobe.

Top module: `repl_victim_sel`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `victim_way` is 0 for every set under every policy. At reset each FIFO pointer and the random counter clear to 0, and each LRU list holds way 0 as oldest up to way E-1 as newest.
- R2: FIFO: `victim_way` equals the pointer of set `repl_set`. A `repl_req` for that set advances the pointer by one on the clock edge, and the pointer wraps from E-1 to 0.
- R3: FIFO: a replacement in one set leaves the pointers of all other sets unchanged. Access notifications have no effect on any pointer.
- R4: Random: `victim_way` is the shared counter value and is the same whichever set `repl_set` names.
- R5: Random, advance setting 0 (per clock): the counter steps by one modulo E on every clock edge after reset.
- R6: Random, advance setting 1 (per reference): the counter steps by one modulo E on each edge where `access_vld` is high, and only then.
- R7: Random, advance setting 2 (per replacement): the counter steps by one modulo E on each edge where `repl_req` is high, and only then.
- R8: LRU: `victim_way` is the way of set `repl_set` that was reported least recently through `access_*`. Ways never reported since reset count as older than any reported way, in the initial order.
- R9: LRU: an access moves its way to the newest position. Every way that was newer shifts one position toward oldest, and older ways keep their positions. An access to the way that is already newest leaves the order unchanged.
- R10: LRU: an access changes only the list of `access_set`, and `repl_req` has no effect on any list.
- R11: `victim_way` is always below E. On a cycle with a strobe it still reflects the state before that strobe's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| repl_req | input | 1 | A replacement is committed in set `repl_set` on this edge |
| repl_set | input | log2(SETS) | Set whose victim is requested |
| access_vld | input | 1 | A hit or fill is being reported |
| access_set | input | log2(SETS) | Set of the reported access |
| access_way | input | log2(WAYS) | Way of the reported access |
| victim_way | output | log2(WAYS) | Way to evict from set `repl_set` |

## Verification
The properties assume that `access_way` is below E, that set numbers are below SETS, and that at most one access is reported per cycle. They also assume that nothing happens in the cycle reset is released other than what the checker's own reset-follow flag screens out. The LRU ordering checks rely on the way number being valid: an out-of-range way would match no list entry and corrupt the order. The stimulus uses a four-way, eight-set configuration and only drives in-range way and set numbers. Replace and access strobes are sometimes raised together on the same set, to show that the victim seen in a cycle reflects only earlier edges.

// File: rtl/repl_pkg.sv
package repl_pkg;
  typedef enum logic [1:0] {
    POL_FIFO = 2'd0,
    POL_RAND = 2'd1,
    POL_LRU  = 2'd2
  } policy_e;

  typedef enum logic [1:0] {
    ADV_CYCLE = 2'd0,
    ADV_REF   = 2'd1,
    ADV_REPL  = 2'd2
  } rand_adv_e;
endpackage

// File: rtl/repl_fifo_ptrs.sv
module repl_fifo_ptrs #(
  parameter int WAYS = 4,
  parameter int SETS = 8,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             repl_req,
  input  logic [SET_W-1:0] repl_set,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] ptr_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (repl_req) begin
      ptr_q[repl_set] <= (ptr_q[repl_set] == WAY_W'(WAYS - 1)) ? '0 : ptr_q[repl_set] + 1'b1;
    end
  end

  assign victim = ptr_q[repl_set];
endmodule

// File: rtl/repl_rand_ctr.sv
module repl_rand_ctr #(
  parameter int WAYS = 4,
  parameter repl_pkg::rand_adv_e ADV = repl_pkg::ADV_REPL,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             access_vld,
  input  logic             repl_req,
  output logic [WAY_W-1:0] victim
);
  logic             step;
  logic [WAY_W-1:0] cnt_q;
  logic             unused_strobes;

  assign unused_strobes = access_vld ^ repl_req;

  generate
    if (ADV == repl_pkg::ADV_CYCLE) begin : g_cycle
      assign step = 1'b1;
    end else if (ADV == repl_pkg::ADV_REF) begin : g_ref
      assign step = access_vld;
    end else begin : g_repl
      assign step = repl_req;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (step) cnt_q <= (cnt_q == WAY_W'(WAYS - 1)) ? '0 : cnt_q + 1'b1;
  end

  assign victim = cnt_q;
endmodule

// File: rtl/repl_lru_order.sv
module repl_lru_order #(
  parameter int WAYS = 4,
  parameter int SETS = 8,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             access_vld,
  input  logic [SET_W-1:0] access_set,
  input  logic [WAY_W-1:0] access_way,
  input  logic [SET_W-1:0] repl_set,
  output logic [WAY_W-1:0] victim
);
  // ord_q[s][0] is the oldest way of set s, ord_q[s][WAYS-1] the newest
  logic [WAY_W-1:0] ord_q [SETS][WAYS];
  logic [WAY_W-1:0] cur_row [WAYS];
  logic [WAY_W-1:0] nxt_row [WAYS];
  logic [WAY_W-1:0] hit_pos;

  always_comb begin
    cur_row = ord_q[access_set];
    hit_pos = '0;
    for (int p = 0; p < WAYS; p++) begin
      if (cur_row[p] == access_way) hit_pos = WAY_W'(p);
    end
    for (int p = 0; p < WAYS - 1; p++) begin
      nxt_row[p] = (WAY_W'(p) >= hit_pos) ? cur_row[p + 1] : cur_row[p];
    end
    nxt_row[WAYS - 1] = access_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int p = 0; p < WAYS; p++)
          ord_q[s][p] <= WAY_W'(p);
    end else if (access_vld) begin
      ord_q[access_set] <= nxt_row;
    end
  end

  assign victim = ord_q[repl_set][0];
endmodule

// File: rtl/repl_victim_sel.sv
module repl_victim_sel #(
  parameter repl_pkg::policy_e   POLICY   = repl_pkg::POL_LRU,
  parameter repl_pkg::rand_adv_e RAND_ADV = repl_pkg::ADV_REPL,
  parameter int WAYS = 4,
  parameter int SETS = 8,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             repl_req,
  input  logic [SET_W-1:0] repl_set,
  input  logic             access_vld,
  input  logic [SET_W-1:0] access_set,
  input  logic [WAY_W-1:0] access_way,
  output logic [WAY_W-1:0] victim_way
);
  generate
    if (POLICY == repl_pkg::POL_FIFO) begin : g_fifo
      logic unused_acc;
      assign unused_acc = access_vld ^ (^access_set) ^ (^access_way);
      repl_fifo_ptrs #(.WAYS(WAYS), .SETS(SETS)) fifo_i (
        .clk(clk), .rst_n(rst_n), .repl_req(repl_req),
        .repl_set(repl_set), .victim(victim_way)
      );
    end else if (POLICY == repl_pkg::POL_RAND) begin : g_rand
      logic unused_sets;
      assign unused_sets = (^repl_set) ^ (^access_set) ^ (^access_way);
      repl_rand_ctr #(.WAYS(WAYS), .ADV(RAND_ADV)) rand_i (
        .clk(clk), .rst_n(rst_n), .access_vld(access_vld),
        .repl_req(repl_req), .victim(victim_way)
      );
    end else begin : g_lru
      logic unused_req;
      assign unused_req = repl_req;
      repl_lru_order #(.WAYS(WAYS), .SETS(SETS)) lru_i (
        .clk(clk), .rst_n(rst_n), .access_vld(access_vld),
        .access_set(access_set), .access_way(access_way),
        .repl_set(repl_set), .victim(victim_way)
      );
    end
  endgenerate
endmodule

// File: rtl/repl_victim_sel_chk.sv
module repl_victim_sel_chk #(
  parameter repl_pkg::policy_e   POLICY   = repl_pkg::POL_LRU,
  parameter repl_pkg::rand_adv_e RAND_ADV = repl_pkg::ADV_REPL,
  parameter int WAYS = 4,
  parameter int SETS = 8,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             repl_req,
  input logic [SET_W-1:0] repl_set,
  input logic             access_vld,
  input logic [SET_W-1:0] access_set,
  input logic [WAY_W-1:0] access_way,
  input logic [WAY_W-1:0] victim_way
);
  logic live_q;
  logic unused_chk;
  assign unused_chk = repl_req ^ access_vld ^ (^access_set) ^ (^access_way) ^ (^repl_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else live_q <= 1'b1;
  end

  function automatic logic [WAY_W-1:0] nxt(input logic [WAY_W-1:0] v);
    return (v == WAY_W'(WAYS - 1)) ? '0 : v + 1'b1;
  endfunction

  a_r11_victim_range: assert property (@(posedge clk) disable iff (!rst_n)
    victim_way <= WAY_W'(WAYS - 1));

  generate
    if (POLICY == repl_pkg::POL_FIFO) begin : g_fifo
      a_r2_fifo_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && repl_req) ##1 $stable(repl_set) |-> victim_way == nxt($past(victim_way)));
      a_r3_fifo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !repl_req) ##1 $stable(repl_set) |-> $stable(victim_way));
    end else if (POLICY == repl_pkg::POL_RAND) begin : g_rand
      if (RAND_ADV == repl_pkg::ADV_CYCLE) begin : g_cyc
        a_r5_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
          live_q |=> victim_way == nxt($past(victim_way)));
      end else if (RAND_ADV == repl_pkg::ADV_REF) begin : g_ref
        a_r6_ref_step: assert property (@(posedge clk) disable iff (!rst_n)
          (live_q && access_vld) |=> victim_way == nxt($past(victim_way)));
        a_r6_ref_hold: assert property (@(posedge clk) disable iff (!rst_n)
          (live_q && !access_vld) |=> $stable(victim_way));
      end else begin : g_rep
        a_r7_repl_step: assert property (@(posedge clk) disable iff (!rst_n)
          (live_q && repl_req) |=> victim_way == nxt($past(victim_way)));
        // R4: the victim does not move with repl_set alone
        a_r4_set_independent: assert property (@(posedge clk) disable iff (!rst_n)
          (live_q && !repl_req) |=> $stable(victim_way));
      end
    end else begin : g_lru
      a_r9_touched_not_victim: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && access_vld) ##1 (repl_set == $past(access_set)) |-> victim_way != $past(access_way));
      a_r10_lru_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !access_vld) ##1 $stable(repl_set) |-> $stable(victim_way));
    end
  endgenerate
endmodule

bind repl_victim_sel repl_victim_sel_chk #(
  .POLICY(POLICY), .RAND_ADV(RAND_ADV), .WAYS(WAYS), .SETS(SETS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .repl_req(repl_req), .repl_set(repl_set),
  .access_vld(access_vld), .access_set(access_set), .access_way(access_way),
  .victim_way(victim_way)
);

// File: tb/repl_victim_sel_tb_top.sv
module repl_victim_sel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int S = 8;
  localparam int NVEC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic repl_req = 1'b0;
  logic [2:0] repl_set = '0;
  logic access_vld = 1'b0;
  logic [2:0] access_set = '0;
  logic [1:0] access_way = '0;
  logic [1:0] v_lru, v_fifo, v_rcyc, v_rref, v_rrep;

  int checks = 0;
  int failures = 0;

  // bench-side reference state, derived from the requirements
  int m_ord [S][W];
  int m_fifo [S];
  int m_cyc, m_ref, m_rep;

  always #(CLK_PERIOD / 2) clk = ~clk;

  repl_victim_sel #(.POLICY(repl_pkg::POL_LRU)) dut_i (
    .clk(clk), .rst_n(rst_n), .repl_req(repl_req), .repl_set(repl_set),
    .access_vld(access_vld), .access_set(access_set), .access_way(access_way),
    .victim_way(v_lru));
  repl_victim_sel #(.POLICY(repl_pkg::POL_FIFO)) dut_fifo_i (
    .clk(clk), .rst_n(rst_n), .repl_req(repl_req), .repl_set(repl_set),
    .access_vld(access_vld), .access_set(access_set), .access_way(access_way),
    .victim_way(v_fifo));
  repl_victim_sel #(.POLICY(repl_pkg::POL_RAND), .RAND_ADV(repl_pkg::ADV_CYCLE)) dut_rcyc_i (
    .clk(clk), .rst_n(rst_n), .repl_req(repl_req), .repl_set(repl_set),
    .access_vld(access_vld), .access_set(access_set), .access_way(access_way),
    .victim_way(v_rcyc));
  repl_victim_sel #(.POLICY(repl_pkg::POL_RAND), .RAND_ADV(repl_pkg::ADV_REF)) dut_rref_i (
    .clk(clk), .rst_n(rst_n), .repl_req(repl_req), .repl_set(repl_set),
    .access_vld(access_vld), .access_set(access_set), .access_way(access_way),
    .victim_way(v_rref));
  repl_victim_sel #(.POLICY(repl_pkg::POL_RAND), .RAND_ADV(repl_pkg::ADV_REPL)) dut_rrep_i (
    .clk(clk), .rst_n(rst_n), .repl_req(repl_req), .repl_set(repl_set),
    .access_vld(access_vld), .access_set(access_set), .access_way(access_way),
    .victim_way(v_rrep));

  // each entry: {access_vld, access_set[2:0], access_way[1:0], repl_req, repl_set[2:0]}
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b1, 3'd1, 2'd0, 1'b0, 3'd1},
    {1'b1, 3'd1, 2'd1, 1'b0, 3'd1},
    {1'b1, 3'd1, 2'd2, 1'b0, 3'd1},
    {1'b0, 3'd0, 2'd0, 1'b1, 3'd1},
    {1'b1, 3'd1, 2'd3, 1'b0, 3'd1},
    {1'b1, 3'd1, 2'd0, 1'b0, 3'd1},
    {1'b0, 3'd0, 2'd0, 1'b1, 3'd3},
    {1'b0, 3'd0, 2'd0, 1'b1, 3'd3},
    {1'b1, 3'd3, 2'd2, 1'b1, 3'd3},
    {1'b1, 3'd0, 2'd1, 1'b0, 3'd0},
    {1'b0, 3'd0, 2'd0, 1'b0, 3'd1},
    {1'b0, 3'd0, 2'd0, 1'b1, 3'd1},
    {1'b1, 3'd7, 2'd3, 1'b0, 3'd7},
    {1'b1, 3'd7, 2'd1, 1'b0, 3'd7},
    {1'b0, 3'd0, 2'd0, 1'b1, 3'd7},
    {1'b0, 3'd0, 2'd0, 1'b0, 3'd3},
    {1'b1, 3'd1, 2'd2, 1'b0, 3'd1},
    {1'b1, 3'd1, 2'd2, 1'b0, 3'd1},
    {1'b0, 3'd0, 2'd0, 1'b1, 3'd0},
    {1'b0, 3'd0, 2'd0, 1'b0, 3'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < S; s++) begin
      m_fifo[s] = 0;
      for (int p = 0; p < W; p++) m_ord[s][p] = p;
    end
    m_cyc = 0; m_ref = 0; m_rep = 0;
  endtask

  // called at a falling edge: drive, check before the rising edge, model that edge
  task automatic step(input bit av, input int as, input int aw, input bit rq, input int rs);
    int pos;
    access_vld = av; access_set = 3'(as); access_way = 2'(aw);
    repl_req = rq; repl_set = 3'(rs);
    #1;
    chk("R8 R9 R10 R11 lru victim", int'(v_lru), m_ord[rs][0]);
    chk("R2 R3 R11 fifo victim", int'(v_fifo), m_fifo[rs]);
    chk("R4 R5 rand per-clock victim", int'(v_rcyc), m_cyc);
    chk("R4 R6 rand per-reference victim", int'(v_rref), m_ref);
    chk("R4 R7 rand per-replacement victim", int'(v_rrep), m_rep);
    @(negedge clk);
    m_cyc = (m_cyc + 1) % W;
    if (av) m_ref = (m_ref + 1) % W;
    if (rq) begin
      m_rep = (m_rep + 1) % W;
      m_fifo[rs] = (m_fifo[rs] + 1) % W;
    end
    if (av) begin
      pos = 0;
      for (int p = 0; p < W; p++) if (m_ord[as][p] == aw) pos = p;
      for (int p = pos; p < W - 1; p++) m_ord[as][p] = m_ord[as][p + 1];
      m_ord[as][W - 1] = aw;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: strobes during reset are ignored, every victim stays 0
    access_vld = 1'b1; access_set = 3'd2; access_way = 2'd0; repl_req = 1'b1; repl_set = 3'd2;
    #1;
    chk("R1 lru reset", int'(v_lru), 0);
    chk("R1 fifo reset", int'(v_fifo), 0);
    chk("R1 rand reset", int'(v_rcyc), 0);
    @(negedge clk);
    chk("R1 rand ref reset", int'(v_rref), 0);
    chk("R1 rand repl reset", int'(v_rrep), 0);
    access_vld = 1'b0; repl_req = 1'b0;
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][9], int'(VEC[i][8:6]), int'(VEC[i][5:4]), VEC[i][3], int'(VEC[i][2:0]));
    end

    // R2: four replacements in set 2 wrap its pointer back to 0
    for (int k = 0; k < W; k++) step(1'b0, 0, 0, 1'b1, 2);
    step(1'b0, 0, 0, 1'b0, 2);
    chk("R2 fifo wrap to zero", int'(v_fifo), 0);

    // R9: touching the newest way of a fresh set leaves way 0 as victim
    step(1'b1, 5, 3, 1'b0, 5);
    step(1'b0, 0, 0, 1'b0, 5);
    chk("R9 newest touch keeps order", int'(v_lru), 0);

    // R8: touch ways 0,2,3 of set 6; way 1 becomes least recent
    step(1'b1, 6, 0, 1'b0, 6);
    step(1'b1, 6, 2, 1'b0, 6);
    step(1'b1, 6, 3, 1'b0, 6);
    step(1'b0, 0, 0, 1'b0, 6);
    chk("R8 untouched way is victim", int'(v_lru), 1);

    // R10: replace strobes on set 6 do not move the LRU victim
    step(1'b0, 0, 0, 1'b1, 6);
    step(1'b0, 0, 0, 1'b1, 6);
    step(1'b0, 0, 0, 1'b0, 6);
    chk("R10 replace ignored by lru", int'(v_lru), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule